// File: doc/BRIEF.md
# Guarded Single-Precision Compare-Greater Unit

This unit takes two IEEE-754 single-precision operands and returns a 32-bit integer answer. The answer is 1 when the first operand is strictly larger than the second, and 0 in every other case. One cycle after the operation is issued, the answer and a write-enable appear on registered outputs. The lowest bit of a guard word decides whether the operation takes effect. When that bit is clear, nothing is written and no flag changes.

The unit also owns a sticky exception-status register. The compare raises two flags into it:
- invalid, for any NaN operand;
- flush-to-zero, when a subnormal operand was replaced by zero.

Other arithmetic units that issue in the same cycle can OR their own flag updates in through a merge input. Bits in the register only clear or change through an explicit status-write port, and that write overrides everything else in its cycle.

A flags-only variant reuses the same datapath. It returns, as the integer result, the flags that the compare would have raised, and it leaves the status register alone.

Top module: `fgt_unit`

## Requirements
- R1: With the guard true, the result is the integer 1 when operand A is strictly greater than operand B, and 0 otherwise, including when the two are equal (3.0 vs 3.0 gives 0).
- R2: The ordering follows the sign and magnitude of single precision: +INF > -INF gives 1, +INF vs +INF gives 0, -1.0 > -2.0 gives 1, and -2.0 > -1.0 gives 0.
- R3: +0 and -0 compare equal, so either order gives 0.
- R4: A subnormal operand (exponent field 0, fraction non-zero) is compared as zero and raises the flush-to-zero flag at status bit 1. A subnormal compared with a zero therefore gives 0.
- R5: If either operand is a NaN (exponent field all ones, fraction non-zero, either sign), the result is 0 and the invalid flag at status bit 0 is raised.
- R6: `res_we` and `res_data` update on the first rising edge after an issue with the guard true. The status register takes the raised flags on that same edge.
- R7: Only bit 0 of `guard_word` is used. When it is 0, `res_we` stays 0, `res_data` keeps its value, and this operation changes no status flag. The other guard bits have no effect.
- R8: Status flags are sticky: once set, they stay set across later operations until a status write.
- R9: On every edge without a status write, each status bit becomes the OR of its current value, `ext_flags`, and the flags of a guarded compare. `ext_flags` is merged even when this unit does not issue.
- R10: When `stat_wr_en` is high, all status bits load `stat_wr_data` on the next edge. This takes priority over the same-cycle flags from the compare and from `ext_flags`.
- R11: With `op_flags_only` high and the guard true, `res_data` is the zero-extended flag vector the compare would raise (invalid at bit 0, flush-to-zero at bit 1), `res_we` is 1, and the status register is not updated by the operation.
- R12: After reset, `res_we` is 0, `res_data` is 0 and all status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Issue strobe for one operation |
| op_flags_only | input | 1 | Selects the flags-only variant |
| guard_word | input | 32 | Guard operand; only bit 0 is used |
| src_a | input | 32 | First single-precision operand |
| src_b | input | 32 | Second single-precision operand |
| ext_flags | input | 5 | Flag updates from other units issuing this cycle |
| stat_wr_en | input | 1 | Explicit status-register write |
| stat_wr_data | input | 5 | Value loaded by a status write |
| res_data | output | 32 | Integer result |
| res_we | output | 1 | Destination write enable |
| stat_flags | output | 5 | Sticky exception status |

## Verification
Two things can change the status register on the same edge: the compare's own flag update and an external action. The external action is either the merge input or an explicit status write. The bench issues NaN and subnormal compares while also driving `ext_flags` on other bits, and expects the union of those bits with the old value. It then issues a NaN compare in the same cycle as a status write, and expects exactly the written value with no invalid bit. Another case drives `ext_flags` while the guard is false. There the merged bits must appear and the compare's flags must not.

// File: rtl/fgt_pkg.sv
package fgt_pkg;

   // Classification of one operand, as seen by the comparator.
   typedef struct packed {
      logic nan;
      logic denorm;
   } fclass_t;

endpackage

// File: rtl/fgt_classify.sv
module fgt_classify
   import fgt_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input  logic [EXP_W+MAN_W:0] val,
   output fclass_t              cls,
   output logic [EXP_W+MAN_W:0] key
);
   localparam int W = EXP_W + MAN_W + 1;
   localparam logic [W-1:0] MSB = {1'b1, {(W-1){1'b0}}};

   logic [EXP_W-1:0] exp_f;
   logic [MAN_W-1:0] man_f;
   logic             exp_max, exp_min, man_nz;

   always_comb begin
      exp_f   = val[W-2 -: EXP_W];
      man_f   = val[MAN_W-1:0];
      exp_max = &exp_f;
      exp_min = ~|exp_f;
      man_nz  = |man_f;
      cls.nan    = exp_max & man_nz;
      cls.denorm = exp_min & man_nz;
      // Order-preserving unsigned key; every zero (incl. flushed) maps to one code.
      if (exp_min)
         key = MSB;
      else if (val[W-1])
         key = ~val;
      else
         key = val | MSB;
   end
endmodule

// File: rtl/fgt_compare.sv
module fgt_compare
   import fgt_pkg::*;
#(
   parameter int OP_W    = 32,
   parameter int FLAG_W  = 5,
   parameter int INV_POS = 0,
   parameter int IFZ_POS = 1
) (
   input  fclass_t           cls_a,
   input  fclass_t           cls_b,
   input  logic [OP_W-1:0]   key_a,
   input  logic [OP_W-1:0]   key_b,
   output logic              gt,
   output logic [FLAG_W-1:0] raised
);
   logic any_nan;

   always_comb begin
      any_nan = cls_a.nan | cls_b.nan;
      gt      = ~any_nan & (key_a > key_b);
      raised  = '0;
      raised[INV_POS] = any_nan;
      raised[IFZ_POS] = cls_a.denorm | cls_b.denorm;
   end
endmodule

// File: rtl/fgt_status.sv
module fgt_status #(
   parameter int FLAG_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [FLAG_W-1:0] wr_data,
   input  logic [FLAG_W-1:0] ext_upd,
   input  logic              own_en,
   input  logic [FLAG_W-1:0] own_upd,
   output logic [FLAG_W-1:0] flags
);
   for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
      logic set_i;
      assign set_i = ext_upd[i] | (own_en & own_upd[i]);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            flags[i] <= 1'b0;
         else if (wr_en)
            flags[i] <= wr_data[i];
         else if (set_i)
            flags[i] <= 1'b1;
      end
   end
endmodule

// File: rtl/fgt_unit.sv
module fgt_unit
   import fgt_pkg::*;
#(
   parameter int  EXP_W         = 8,
   parameter int  MAN_W         = 23,
   parameter int  RES_W         = 32,
   parameter int  GUARD_W       = 32,
   parameter int  FLAG_W        = 5,
   parameter int  INV_POS       = 0,
   parameter int  IFZ_POS       = 1,
   parameter bit  FLAGS_ONLY_EN = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   op_valid,
   input  logic                   op_flags_only,
   input  logic [GUARD_W-1:0]     guard_word,
   input  logic [EXP_W+MAN_W:0]   src_a,
   input  logic [EXP_W+MAN_W:0]   src_b,
   input  logic [FLAG_W-1:0]      ext_flags,
   input  logic                   stat_wr_en,
   input  logic [FLAG_W-1:0]      stat_wr_data,
   output logic [RES_W-1:0]       res_data,
   output logic                   res_we,
   output logic [FLAG_W-1:0]      stat_flags
);
   localparam int OP_W = EXP_W + MAN_W + 1;

   if (EXP_W < 2 || MAN_W < 1)                      begin : g_bad_fmt  $error("fgt_unit: format too narrow"); end
   if (RES_W < FLAG_W || RES_W < 1)                 begin : g_bad_res  $error("fgt_unit: RES_W below FLAG_W"); end
   if (INV_POS >= FLAG_W || IFZ_POS >= FLAG_W)      begin : g_bad_pos  $error("fgt_unit: flag position out of range"); end
   if (INV_POS == IFZ_POS)                          begin : g_bad_dup  $error("fgt_unit: flag positions collide"); end
   if (GUARD_W < 2)                                 begin : g_bad_grd  $error("fgt_unit: GUARD_W below 2"); end

   fclass_t           cls [2];
   logic [OP_W-1:0]   key [2];
   logic [OP_W-1:0]   opnd [2];
   logic              gt;
   logic [FLAG_W-1:0] raised;
   logic              take, fo_sel;
   logic              unused_guard;

   assign opnd[0]      = src_a;
   assign opnd[1]      = src_b;
   assign unused_guard = ^guard_word[GUARD_W-1:1];
   assign take         = op_valid & guard_word[0];

   for (genvar k = 0; k < 2; k++) begin : g_cls
      fgt_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
         .val (opnd[k]),
         .cls (cls[k]),
         .key (key[k])
      );
   end

   fgt_compare #(
      .OP_W(OP_W), .FLAG_W(FLAG_W), .INV_POS(INV_POS), .IFZ_POS(IFZ_POS)
   ) u_cmp (
      .cls_a  (cls[0]),
      .cls_b  (cls[1]),
      .key_a  (key[0]),
      .key_b  (key[1]),
      .gt     (gt),
      .raised (raised)
   );

   if (FLAGS_ONLY_EN) begin : g_fo
      assign fo_sel = op_flags_only;
   end else begin : g_no_fo
      logic unused_fo;
      assign unused_fo = op_flags_only;
      assign fo_sel    = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_we   <= 1'b0;
         res_data <= '0;
      end else begin
         res_we <= take;
         if (take)
            res_data <= fo_sel ? RES_W'(raised) : RES_W'(gt);
      end
   end

   fgt_status #(.FLAG_W(FLAG_W)) u_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (stat_wr_en),
      .wr_data (stat_wr_data),
      .ext_upd (ext_flags),
      .own_en  (take & ~fo_sel),
      .own_upd (raised),
      .flags   (stat_flags)
   );
endmodule

// File: rtl/fgt_unit_chk.sv
module fgt_unit_chk #(
   parameter int EXP_W   = 8,
   parameter int MAN_W   = 23,
   parameter int RES_W   = 32,
   parameter int GUARD_W = 32,
   parameter int FLAG_W  = 5,
   parameter int INV_POS = 0
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 op_valid,
   input logic                 op_flags_only,
   input logic [GUARD_W-1:0]   guard_word,
   input logic [EXP_W+MAN_W:0] src_a,
   input logic [EXP_W+MAN_W:0] src_b,
   input logic [FLAG_W-1:0]    ext_flags,
   input logic                 stat_wr_en,
   input logic [FLAG_W-1:0]    stat_wr_data,
   input logic [RES_W-1:0]     res_data,
   input logic                 res_we,
   input logic [FLAG_W-1:0]    stat_flags
);
   logic issue, a_nan, b_nan;
   assign issue = op_valid & guard_word[0];
   assign a_nan = (&src_a[EXP_W+MAN_W-1:MAN_W]) & (|src_a[MAN_W-1:0]);
   assign b_nan = (&src_b[EXP_W+MAN_W-1:MAN_W]) & (|src_b[MAN_W-1:0]);

   AST_WE_FOLLOWS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
      issue |=> res_we);                                                       // R6
   AST_NO_WE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !issue |=> !res_we);                                                     // R7
   AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !issue |=> $stable(res_data));                                           // R7
   AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_wr_en |=> ((stat_flags & $past(stat_flags)) == $past(stat_flags))); // R8
   AST_MERGE_EXT: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_wr_en |=> ((stat_flags & $past(ext_flags)) == $past(ext_flags)));   // R9
   AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      stat_wr_en |=> (stat_flags == $past(stat_wr_data)));                     // R10
   AST_NAN_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && !op_flags_only && !stat_wr_en && (a_nan || b_nan))
      |=> (stat_flags[INV_POS] && res_data == '0));                             // R5
   AST_CMP_BOOLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && !op_flags_only) |=> (res_data <= 1));                          // R1
endmodule

bind fgt_unit fgt_unit_chk #(
   .EXP_W(EXP_W), .MAN_W(MAN_W), .RES_W(RES_W), .GUARD_W(GUARD_W),
   .FLAG_W(FLAG_W), .INV_POS(INV_POS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_flags_only(op_flags_only),
   .guard_word(guard_word), .src_a(src_a), .src_b(src_b), .ext_flags(ext_flags),
   .stat_wr_en(stat_wr_en), .stat_wr_data(stat_wr_data), .res_data(res_data),
   .res_we(res_we), .stat_flags(stat_flags)
);

// File: tb/tb_fgt_unit.sv
module tb_fgt_unit;
   localparam int NV = 14;
   localparam logic [31:0] P3 = 32'h40400000, P1 = 32'h3f800000, P0 = 32'h0;
   localparam logic [31:0] N0 = 32'h80000000, PINF = 32'h7f800000, NINF = 32'hff800000;
   localparam logic [31:0] QNAN = 32'hffffffff, PNAN = 32'h7fc00000, DEN = 32'h00400000;
   localparam logic [31:0] NM1 = 32'hbf800000, NM2 = 32'hc0000000, NDEN = 32'h80000001;

   // operand A, operand B, expected result, expected {IFZ,INV}
   localparam logic [31:0] VA [NV] = '{P3, P3, P1, P3, P3, PINF, P1, PINF, P0, N0, DEN, NM1, NM2, PNAN};
   localparam logic [31:0] VB [NV] = '{P0, P3, P3, P1, QNAN, NINF, DEN, PINF, N0, P0, P0, NM2, NM1, P1};
   localparam logic        VR [NV] = '{1, 0, 0, 1, 0, 1, 1, 0, 0, 0, 0, 1, 0, 0};
   localparam logic [1:0]  VF [NV] = '{0, 0, 0, 0, 1, 0, 2, 0, 0, 0, 2, 0, 0, 1};

   logic        clk = 0, rst_n = 0;
   logic        op_valid = 0, op_flags_only = 0, stat_wr_en = 0;
   logic [31:0] guard_word = 0, src_a = 0, src_b = 0;
   logic [4:0]  ext_flags = 0, stat_wr_data = 0;
   logic [31:0] res_data;
   logic        res_we;
   logic [4:0]  stat_flags;
   int checks = 0, fails = 0;
   bit done = 0;

   always #2 clk = ~clk;

   fgt_unit dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_flags_only(op_flags_only),
      .guard_word(guard_word), .src_a(src_a), .src_b(src_b), .ext_flags(ext_flags),
      .stat_wr_en(stat_wr_en), .stat_wr_data(stat_wr_data), .res_data(res_data),
      .res_we(res_we), .stat_flags(stat_flags)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Drive one cycle of stimulus on a falling edge, then return at the next
   // falling edge, after the capturing rising edge.
   task automatic cyc(input logic v, input logic [31:0] g, input logic [31:0] a,
                      input logic [31:0] b, input logic fo, input logic [4:0] ext,
                      input logic wr, input logic [4:0] wd);
      @(negedge clk);
      op_valid = v; guard_word = g; src_a = a; src_b = b; op_flags_only = fo;
      ext_flags = ext; stat_wr_en = wr; stat_wr_data = wd;
      @(negedge clk);
      op_valid = 0; ext_flags = 0; stat_wr_en = 0; op_flags_only = 0;
   endtask

   task automatic clr();
      cyc(0, 0, 0, 0, 0, 0, 1, 5'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check("R12 res_we", {31'd0, res_we}, 0);
      check("R12 res_data", res_data, 0);
      check("R12 stat", {27'd0, stat_flags}, 0);

      // R1 R2 R3 R4 R5 R6 vector walk
      for (int i = 0; i < NV; i++) begin
         clr();
         cyc(1, 1, VA[i], VB[i], 0, 0, 0, 0);
         check($sformatf("R6 we v%0d", i), {31'd0, res_we}, 1);
         check($sformatf("R1/R2/R3 res v%0d", i), res_data, {31'd0, VR[i]});
         check($sformatf("R4/R5 flags v%0d", i), {27'd0, stat_flags}, {30'd0, VF[i]});
      end
      // R3: subnormal with negative sign against -0
      clr();
      cyc(1, 1, NDEN, N0, 0, 0, 0, 0);
      check("R4 neg denorm res", res_data, 0);
      check("R4 neg denorm ifz", {27'd0, stat_flags}, 32'd2);

      // R7 guard gating
      clr();
      cyc(1, 1, P3, P1, 0, 0, 0, 0);
      cyc(1, 0, QNAN, P1, 0, 0, 0, 0);
      check("R7 guard0 we", {31'd0, res_we}, 0);
      check("R7 guard0 data held", res_data, 1);
      check("R7 guard0 no flags", {27'd0, stat_flags}, 0);
      cyc(1, 32'hFFFFFFFE, DEN, P0, 0, 0, 0, 0);
      check("R7 upper guard bits ignored we", {31'd0, res_we}, 0);
      check("R7 upper guard bits ignored flags", {27'd0, stat_flags}, 0);
      cyc(1, 32'h3, P1, P3, 0, 0, 0, 0);
      check("R7 guard bit0 true we", {31'd0, res_we}, 1);
      check("R7 guard bit0 true res", res_data, 0);

      // R8 sticky
      clr();
      cyc(1, 1, QNAN, P1, 0, 0, 0, 0);
      cyc(1, 1, P3, P1, 0, 0, 0, 0);
      check("R8 inv sticky", {27'd0, stat_flags}, 1);
      check("R8 later result", res_data, 1);
      cyc(1, 1, DEN, P1, 0, 0, 0, 0);
      check("R8 accumulate", {27'd0, stat_flags}, 3);

      // R9 merge with external updates
      clr();
      cyc(1, 1, P1, DEN, 0, 5'b01000, 0, 0);
      check("R9 merge same cycle", {27'd0, stat_flags}, 32'b01010);
      cyc(1, 0, QNAN, P1, 0, 5'b10000, 0, 0);
      check("R9 ext while guard false", {27'd0, stat_flags}, 32'b11010);

      // R10 write priority
      cyc(1, 1, QNAN, DEN, 0, 5'b00001, 1, 5'b00100);
      check("R10 write beats updates", {27'd0, stat_flags}, 32'b00100);
      clr();
      check("R10 write clears", {27'd0, stat_flags}, 0);

      // R11 flags-only variant
      cyc(1, 1, QNAN, DEN, 1, 0, 0, 0);
      check("R11 fo we", {31'd0, res_we}, 1);
      check("R11 fo res", res_data, 3);
      check("R11 fo status untouched", {27'd0, stat_flags}, 0);
      cyc(1, 1, P3, P1, 1, 0, 0, 0);
      check("R11 fo clean res", res_data, 0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule